// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates among a large set of level-sensitive interrupt request lines on behalf of a single core. Each line carries a 4-bit urgency value and an enable bit, both set through a small register write port. A global grouping code splits every urgency value into an upper pre-emption part and a lower sub-priority part. The split can change at run time. Requests are latched as pending. Each cycle the block picks the most urgent pending, enabled line and decides whether it may interrupt the work now running. When it may, the block issues a one-cycle take pulse with the line number toward the core.

Nesting is tracked by an internal stack holding the urgency value of every taken interrupt that has not yet finished. Only the pre-emption part of the value on top of the stack is used when deciding whether a new request may nest. The sub-priority bits serve only to order pending requests of equal pre-emption level. An end-of-service pulse from the core pops the stack, so the interrupted level becomes the running level again. A global mask input holds off every take without losing pending requests.

Top module: `grp_irq_arbiter`

## Requirements
- R1: After reset, take_o is 0, depth_o is 0 and run_prio_o is 0. Every line is disabled with urgency 0, and the grouping code is 0.
- R2: The winner is the pending, enabled line with the numerically smallest 4-bit urgency value. A request held high before a clock edge yields take_o=1 with take_id_o equal to the winner after the following edge, for one cycle. Line word writes use address = line number, with wdata[3:0] as urgency and wdata[4] as enable.
- R3: The grouping code is written at address NUM_LINES, in wdata[10:8]. Codes 7, 6, 5, 4 and 3 give 0, 1, 2, 3 and 4 pre-emption bits, and codes 0 to 2 act like code 3. The pre-emption level is the upper bits of the urgency value.
- R4: While depth_o is nonzero, a pending line is taken only if its pre-emption level is strictly lower than that of run_prio_o. Equal levels never nest, whatever the sub-priority.
- R5: Among pending lines with the same full urgency value, the lowest line number wins. A lower sub-priority wins among lines of equal level.
- R6: A disabled line is never taken, but its request is still latched as pending. It is taken once the line is enabled.
- R7: While mask_i is 1, take_o stays 0 and pending requests are kept. After mask_i returns to 0, arbitration resumes.
- R8: On a take, the winner's pending bit clears, depth_o rises by one and run_prio_o becomes the winner's urgency.
- R9: eoi_i pops the stack, restoring the previous run_prio_o. At depth 0, eoi_i has no effect.
- R10: When eoi_i and a take fall in the same cycle, the candidate is judged against the level beneath the popped entry. The new entry replaces the popped one, and depth_o is unchanged.
- R11: When depth_o equals NEST_DEPTH, no take occurs until an end-of-service frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | NUM_LINES | Level request per line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Line number, or NUM_LINES for the grouping word |
| cfg_wdata_i | input | 16 | Write data |
| mask_i | input | 1 | Global block of all takes |
| eoi_i | input | 1 | End-of-service pulse from the core |
| take_o | output | 1 | One-cycle take pulse toward the core |
| take_id_o | output | ID_W | Line number of the taken interrupt |
| depth_o | output | CNT_W | Current nesting depth |
| run_prio_o | output | 4 | Urgency of the running interrupt (0 when idle) |

## Verification
End-of-service and a new take can occur in the same clock cycle. The bench provokes this on purpose: a blocked request waits as pending, and then eoi_i is pulsed. The bench checks that the pending request is taken on that same edge, against the level uncovered by the pop. It then checks that depth_o keeps its value and run_prio_o shows the newcomer. The same overlap at a full stack shows that the freed entry is reused at once. Following pops must then restore the earlier levels in order.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int PRIO_W = 4;
    localparam int CODE_W = 3;
    localparam int PB_W   = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    // Number of pre-emption bits selected by a grouping code.
    function automatic logic [PB_W-1:0] pre_bits_of(input logic [CODE_W-1:0] code);
        case (code)
            3'd7:    return 3'd0;
            3'd6:    return 3'd1;
            3'd5:    return 3'd2;
            3'd4:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // Pre-emption level: the upper pre-bits of the urgency value.
    function automatic prio_t level_of(input prio_t p, input logic [PB_W-1:0] nb);
        return p >> (PRIO_W - int'(nb));
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES = 43,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_LINES-1:0]            en_o,
    output logic [PB_W-1:0]                 pre_bits_o
);
    localparam int EN_BIT   = PRIO_W;
    localparam int CODE_LSB = 8;

    typedef struct packed {
        logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
        logic [NUM_LINES-1:0]             en;
        logic [CODE_W-1:0]                code;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (addr_i == ADDR_W'(i)) begin
                    cfg_d.prio[i] = wdata_i[PRIO_W-1:0];
                    cfg_d.en[i]   = wdata_i[EN_BIT];
                end
            end
            if (addr_i == ADDR_W'(NUM_LINES))
                cfg_d.code = wdata_i[CODE_LSB +: CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign prio_o     = cfg_q.prio;
    assign en_o       = cfg_q.en;
    assign pre_bits_o = pre_bits_of(cfg_q.code);
endmodule

// File: rtl/irq_winner_pick.sv
module irq_winner_pick
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES = 43,
    parameter int ID_W      = 6
) (
    input  logic [NUM_LINES-1:0]            cand_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
    output logic                            found_o,
    output logic [ID_W-1:0]                 id_o,
    output prio_t                           prio_o
);
    // Linear scan; strict compare keeps the lowest index on equal values.
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        prio_o  = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i] < prio_o)) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import grp_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    input  logic             push_i,
    input  prio_t            push_val_i,
    output logic [CNT_W-1:0] depth_o,
    output logic [CNT_W-1:0] depth_after_pop_o,
    output logic             under_valid_o,
    output prio_t            under_o,
    output prio_t            top_o
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [CNT_W-1:0] eff;

    always_comb begin
        eff = stk_q.cnt - CNT_W'(pop_i && stk_q.cnt != '0);
        under_valid_o = (eff != '0);
        under_o = '0;
        top_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (eff == CNT_W'(i + 1))       under_o = stk_q.ent[i];
            if (stk_q.cnt == CNT_W'(i + 1)) top_o   = stk_q.ent[i];
        end
        stk_d     = stk_q;
        stk_d.cnt = eff;
        if (push_i && eff < CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (eff == CNT_W'(i)) stk_d.ent[i] = push_val_i;
            stk_d.cnt = eff + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign depth_o           = stk_q.cnt;
    assign depth_after_pop_o = eff;
endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
    import grp_irq_pkg::*;
#(
    parameter int NUM_LINES  = 43,
    parameter int NEST_DEPTH = 8,
    parameter int DATA_W     = 16,
    parameter int ID_W       = $clog2(NUM_LINES),
    parameter int ADDR_W     = $clog2(NUM_LINES + 1),
    parameter int CNT_W      = $clog2(NEST_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req_i,
    input  logic                 cfg_we_i,
    input  logic [ADDR_W-1:0]    cfg_addr_i,
    input  logic [DATA_W-1:0]    cfg_wdata_i,
    input  logic                 mask_i,
    input  logic                 eoi_i,
    output logic                 take_o,
    output logic [ID_W-1:0]      take_id_o,
    output logic [CNT_W-1:0]     depth_o,
    output logic [PRIO_W-1:0]    run_prio_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic                 take;
        logic [ID_W-1:0]      id;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_LINES-1:0][PRIO_W-1:0] line_prio;
    logic [NUM_LINES-1:0]             line_en;
    logic [PB_W-1:0]                  grp_pre_bits;
    logic                             win_found;
    logic [ID_W-1:0]                  win_id;
    prio_t                            win_prio;
    logic [CNT_W-1:0]                 eff_depth;
    logic                             under_valid;
    prio_t                            under_prio;
    logic                             may_nest;
    logic                             take_now;

    irq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .prio_o(line_prio), .en_o(line_en),
        .pre_bits_o(grp_pre_bits)
    );

    irq_winner_pick #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) i_pick (
        .cand_i(st_q.pend & line_en), .prio_i(line_prio),
        .found_o(win_found), .id_o(win_id), .prio_o(win_prio)
    );

    irq_level_stack #(.DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) i_stack (
        .clk(clk), .rst_n(rst_n), .pop_i(eoi_i), .push_i(take_now),
        .push_val_i(win_prio), .depth_o(depth_o),
        .depth_after_pop_o(eff_depth), .under_valid_o(under_valid),
        .under_o(under_prio), .top_o(run_prio_o)
    );

    always_comb begin
        may_nest = !under_valid ||
                   (level_of(win_prio, grp_pre_bits) < level_of(under_prio, grp_pre_bits));
        take_now = win_found && !mask_i && may_nest && (eff_depth < CNT_W'(NEST_DEPTH));

        st_d      = st_q;
        st_d.pend = st_q.pend | irq_req_i;
        st_d.take = take_now;
        if (take_now) begin
            st_d.id = win_id;
            for (int i = 0; i < NUM_LINES; i++)
                if (win_id == ID_W'(i)) st_d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o    = st_q.take;
    assign take_id_o = st_q.id;
endmodule

// File: rtl/grp_irq_arbiter_chk.sv
module grp_irq_arbiter_chk
    import grp_irq_pkg::*;
#(
    parameter int NEST_DEPTH = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_i,
    input logic             eoi_i,
    input logic             take_o,
    input logic [CNT_W-1:0] depth_o,
    input prio_t            run_prio_o,
    input logic [PB_W-1:0]  pre_bits_i
);
    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(mask_i));

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= CNT_W'(NEST_DEPTH));

    // R8
    push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !$past(eoi_i)) |-> depth_o == $past(depth_o) + CNT_W'(1));

    // R10
    swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(eoi_i) && $past(depth_o) != '0) |-> depth_o == $past(depth_o));

    // R9
    pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && depth_o != '0) |=> (take_o || depth_o == $past(depth_o) - CNT_W'(1)));

    // R4
    strict_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(depth_o) != '0 && !$past(eoi_i)) |->
        level_of(run_prio_o, $past(pre_bits_i)) < level_of($past(run_prio_o), $past(pre_bits_i)));
endmodule

bind grp_irq_arbiter grp_irq_arbiter_chk #(.NEST_DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .eoi_i(eoi_i), .take_o(take_o),
    .depth_o(depth_o), .run_prio_o(run_prio_o), .pre_bits_i(grp_pre_bits)
);

// File: tb/test_grp_irq_arbiter.sv
module test_grp_irq_arbiter;
    localparam int N  = 43;
    localparam int ND = 8;
    localparam int AW = 6;
    localparam int IW = 6;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          mask = 1'b0;
    logic          eoi = 1'b0;
    logic          take;
    logic [IW-1:0] take_id;
    logic [CW-1:0] depth;
    logic [3:0]    run_prio;

    int nchk = 0;
    int nerr = 0;
    bit wd_hit = 1'b0;

    always #5 clk = ~clk;

    grp_irq_arbiter #(.NUM_LINES(N), .NEST_DEPTH(ND)) i_grp_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .cfg_we_i(cfg_we),
        .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .mask_i(mask), .eoi_i(eoi),
        .take_o(take), .take_id_o(take_id), .depth_o(depth), .run_prio_o(run_prio)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = 16'(data);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_line(input int id, input int prio, input bit en);
        wr(id, (int'(en) << 4) | prio);
    endtask

    task automatic set_group(input int code);
        wr(N, code << 8);
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk); irq_req = bits;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic expect_take(input string req, input int id, input int d, input int p);
        @(negedge clk);
        chk(req, "take", int'(take), 1);
        chk(req, "take_id", int'(take_id), id);
        chk(req, "depth", int'(depth), d);
        chk(req, "run_prio", int'(run_prio), p);
    endtask

    task automatic expect_none(input string req, input int d);
        @(negedge clk);
        chk(req, "no take", int'(take), 0);
        chk(req, "depth", int'(depth), d);
    endtask

    // End-of-service pulse; results of the same edge are visible on return.
    task automatic eoi_chk(input string req, input bit tk, input int id, input int d, input int p);
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
        chk(req, "take", int'(take), int'(tk));
        if (tk) chk(req, "take_id", int'(take_id), id);
        chk(req, "depth", int'(depth), d);
        chk(req, "run_prio", int'(run_prio), p);
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "take", int'(take), 0);
        chk("R1", "depth", int'(depth), 0);
        chk("R1", "run_prio", int'(run_prio), 0);
    endtask

    task automatic t_basic;
        set_group(3);
        set_line(5, 9, 1'b1);
        set_line(10, 4, 1'b1);
        pulse(bit_of(5) | bit_of(10));
        expect_take("R2 R8", 10, 1, 4);
        expect_none("R4", 1);
        eoi_chk("R10", 1'b1, 5, 1, 9);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_tie;
        set_line(20, 6, 1'b1);
        set_line(7, 6, 1'b1);
        pulse(bit_of(20) | bit_of(7));
        expect_take("R5 tie", 7, 1, 6);
        eoi_chk("R10", 1'b1, 20, 1, 6);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_sub;
        set_group(5);
        set_line(3, 7, 1'b1);
        set_line(4, 4, 1'b1);
        set_line(30, 8, 1'b1);
        pulse(bit_of(30));
        expect_take("R2", 30, 1, 8);
        pulse(bit_of(3) | bit_of(4));
        expect_take("R5 sub", 4, 2, 4);
        expect_none("R4 equal level", 2);
        eoi_chk("R10", 1'b1, 3, 2, 7);
        eoi_chk("R9 restore", 1'b0, 0, 1, 8);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_groups;
        set_group(7);
        set_line(1, 15, 1'b1);
        set_line(2, 0, 1'b1);
        pulse(bit_of(1));
        expect_take("R3 code7", 1, 1, 15);
        pulse(bit_of(2));
        expect_none("R3 code7", 1);
        eoi_chk("R3 code7", 1'b1, 2, 1, 0);
        eoi_chk("R9", 1'b0, 0, 0, 0);

        set_group(0);
        set_line(2, 14, 1'b1);
        pulse(bit_of(1));
        expect_take("R3 code0", 1, 1, 15);
        pulse(bit_of(2));
        expect_take("R3 code0", 2, 2, 14);
        eoi_chk("R9", 1'b0, 0, 1, 15);
        eoi_chk("R9", 1'b0, 0, 0, 0);

        set_group(4);
        pulse(bit_of(1));
        expect_take("R3 code4", 1, 1, 15);
        pulse(bit_of(2));
        expect_none("R3 code4", 1);
        eoi_chk("R3 code4", 1'b1, 2, 1, 14);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_disabled;
        set_group(3);
        set_line(9, 0, 1'b0);
        pulse(bit_of(9));
        expect_none("R6", 0);
        expect_none("R6", 0);
        set_line(9, 0, 1'b1);
        expect_take("R6", 9, 1, 0);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_mask;
        set_line(11, 5, 1'b1);
        @(negedge clk); mask = 1'b1;
        pulse(bit_of(11));
        for (int k = 0; k < 3; k++) expect_none("R7", 0);
        mask = 1'b0;
        expect_take("R7", 11, 1, 5);
        eoi_chk("R9", 1'b0, 0, 0, 0);
    endtask

    task automatic t_eoi_idle;
        eoi_chk("R9 idle", 1'b0, 0, 0, 0);
    endtask

    task automatic t_full;
        set_group(3);
        for (int i = 0; i < ND; i++) set_line(i, 15 - i, 1'b1);
        set_line(ND, 0, 1'b1);
        for (int i = 0; i < ND; i++) begin
            pulse(bit_of(i));
            expect_take("R11 fill", i, i + 1, 15 - i);
        end
        pulse(bit_of(ND));
        expect_none("R11", ND);
        eoi_chk("R11 R10", 1'b1, ND, ND, 0);
        for (int k = 1; k <= ND; k++)
            eoi_chk("R9 unwind", 1'b0, 0, ND - k, (k == ND) ? 0 : 8 + k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_basic();
                t_tie();
                t_sub();
                t_groups();
                t_disabled();
                t_mask();
                t_eoi_idle();
                t_full();
            end
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule